// File: doc/BRIEF.md
# ADC Conversion Result Buffer

This block sits between an analog-to-digital converter and the system bus. Every conversion-complete strobe from the converter stores the accompanying result word in a small synchronous first-in first-out store, with no software involvement. A consumer then takes results out through a single-cycle pop strobe; the popped word appears on a registered output one cycle later.

There are three ways to consume the data. Software can poll a ready bit and the fill count. It can unmask a ready interrupt and acknowledge it with a clear pulse. Or a DMA engine can be armed so that a request is raised once the fill level reaches a programmed threshold. Two sticky error flags report a result lost to a full store (overrun) and a pop from an empty store (underrun). Each flag has its own clear pulse.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY`: no entries.
- `OCC_PARTIAL`: between 1 and DEPTH-1 entries.
- `OCC_FULL`: DEPTH entries.

The transitions are:
- `FILL`: EMPTY to PARTIAL on an accepted push.
- `TOP_OFF`: PARTIAL to FULL on a push without a pop at DEPTH-1 entries.
- `DRAIN`: FULL to PARTIAL on an accepted pop.
- `EMPTY_OUT`: PARTIAL to EMPTY on a pop without a push at 1 entry.
- `RESET`: any state to EMPTY.

Top module: `adc_result_fifo`

## Requirements
- R1: A synchronous active-high `rst` empties the store and drives `fill_count`, `rd_data`, `is_full`, `not_empty`, `data_ready`, `ovf_flag`, `unf_flag`, `rdy_irq` and `dma_req` to 0.
- R2: A `conv_done` pulse with fewer than DEPTH (32) entries stores `conv_data`. `fill_count` (6 bits) equals the number of stored entries, from 0 to 32. A push and a pop in the same cycle with 1 to 31 entries leave `fill_count` unchanged.
- R3: `is_full` is 1 exactly when 32 entries are stored. `not_empty` and `data_ready` are 1 exactly when at least one entry is stored.
- R4: `conv_done` while the store is full drops the incoming word, keeps the stored contents, and sets `ovf_flag` in the next cycle.
- R5: `rd_pop` while the store is empty leaves the pointers and count unchanged, drives `rd_data` to 0 in the next cycle, and sets `unf_flag`.
- R6: `ovf_flag` and `unf_flag` stay set until their own clear pulse (`ovf_clr`, `unf_clr`). If a new error event and a clear occur in the same cycle, the flag stays set.
- R7: Entries leave in arrival order. `rd_data` shows the popped word in the cycle after `rd_pop` and holds its value while no pop occurs.
- R8: Each accepted push sets a ready-pending bit, and `rdy_clr` clears it; a push in the same cycle as the clear wins. `rdy_irq` is 1 when the bit is pending, `rdy_mask` is 0, and data is stored.
- R9: `dma_req` is 1 exactly when `dma_en` is 1, `fill_count` is non-zero, and `fill_count` is at least `dma_thresh`.
- R10: A push and a pop in the same cycle on an empty store accept the push and count the pop as an underrun. The same on a full store accept the pop and count the push as an overrun, leaving 31 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | Conversion-complete strobe (push) |
| conv_data | input | 26 | Conversion result to store |
| rd_pop | input | 1 | Pop strobe from the reader |
| rd_data | output | 26 | Registered popped word |
| fill_count | output | 6 | Number of stored entries |
| is_full | output | 1 | Store holds 32 entries |
| not_empty | output | 1 | Store holds at least one entry |
| data_ready | output | 1 | Polling ready bit |
| ovf_flag | output | 1 | Sticky overrun flag |
| ovf_clr | input | 1 | Overrun flag clear pulse |
| unf_flag | output | 1 | Sticky underrun flag |
| unf_clr | input | 1 | Underrun flag clear pulse |
| rdy_mask | input | 1 | Ready interrupt mask, 1 = masked |
| rdy_clr | input | 1 | Ready interrupt clear pulse |
| rdy_irq | output | 1 | Ready interrupt |
| dma_en | input | 1 | DMA request enable |
| dma_thresh | input | 6 | DMA fill-level threshold |
| dma_req | output | 1 | DMA request |

## Verification
The bench pushes into a full store and pops from an empty one, then drains the store. A design that overwrote the oldest word, or that stored the rejected word, would return a wrong word during the drain. It also drives a push and a pop together while the store is empty and again while it is full. A design that judged these against the count after the update would report the wrong count or miss the error flag. Clears that coincide with a new event show whether a set loses to its clear. The bench also re-pushes after a ready clear, to catch an interrupt that never re-arms.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/adcf_store.sv
module adcf_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 26,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PW-1:0]    wptr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             rd_en,
    input  logic             rd_void,
    input  logic [PW-1:0]    rptr,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wptr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= cells[rptr];
        end else if (rd_void) begin
            rd_word <= '0;
        end
    end

    // R5: an empty pop yields zero on the output one cycle later
    a_r5_zero_on_void: assert property (@(posedge clk) disable iff (rst)
        rd_void |=> (rd_word == '0));

    // R7: with no pop of either kind the output word holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !rd_void) |=> $stable(rd_word));

endmodule

// File: rtl/adcf_ctrl.sv
module adcf_ctrl
    import adcf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          wr_en,
    output logic          rd_en,
    output logic          ovf_evt,
    output logic          unf_evt,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          nonempty
);

    localparam logic [CW-1:0] CNT_TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_NEAR = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    occ_state_t state, state_nxt;

    // Accept decisions are made on the occupancy at the start of the cycle
    always_comb begin
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        ovf_evt = 1'b0;
        unf_evt = 1'b0;
        unique case (state)
            OCC_EMPTY: begin
                wr_en   = push_req;
                unf_evt = pop_req;
            end
            OCC_PARTIAL: begin
                wr_en = push_req;
                rd_en = pop_req;
            end
            OCC_FULL: begin
                ovf_evt = push_req;
                rd_en   = pop_req;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    // Transition logic (FILL, TOP_OFF, DRAIN, EMPTY_OUT)
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (wr_en) state_nxt = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (wr_en && !rd_en && count == CNT_NEAR) begin
                    state_nxt = OCC_FULL;
                end else if (rd_en && !wr_en && count == CNT_ONE) begin
                    state_nxt = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (rd_en) state_nxt = OCC_PARTIAL;
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    // State register (RESET)
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OCC_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Status outputs decoded from the state
    always_comb begin
        full     = 1'b0;
        nonempty = 1'b0;
        unique case (state)
            OCC_EMPTY:   begin full = 1'b0; nonempty = 1'b0; end
            OCC_PARTIAL: begin full = 1'b0; nonempty = 1'b1; end
            OCC_FULL:    begin full = 1'b1; nonempty = 1'b1; end
            default:     begin full = 1'b0; nonempty = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) begin
                wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            end
            if (rd_en) begin
                rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            end
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: the count never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_TOP);

    // R3: the state and the count agree on emptiness and fullness
    a_r3_empty_match: assert property (@(posedge clk) disable iff (rst)
        (state == OCC_EMPTY) == (count == '0));
    a_r3_full_match: assert property (@(posedge clk) disable iff (rst)
        (state == OCC_FULL) == (count == CNT_TOP));

    // R2: a push and a pop together in the partial state keep the count
    a_r2_pair_stable: assert property (@(posedge clk) disable iff (rst)
        (state == OCC_PARTIAL && push_req && pop_req) |=> $stable(count));

    // R4: a push into a full store without a pop keeps it full
    a_r4_full_keeps: assert property (@(posedge clk) disable iff (rst)
        (state == OCC_FULL && push_req && !pop_req) |=> (count == CNT_TOP));

    // R5: an empty pop moves no read pointer
    a_r5_ptr_still: assert property (@(posedge clk) disable iff (rst)
        (state == OCC_EMPTY && pop_req) |=> $stable(rptr));

endmodule

// File: rtl/adcf_irq.sv
module adcf_irq #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          ovf_evt,
    input  logic          unf_evt,
    input  logic          nonempty,
    input  logic [CW-1:0] count,
    input  logic          ovf_clr,
    input  logic          unf_clr,
    input  logic          rdy_mask,
    input  logic          rdy_clr,
    input  logic          dma_en,
    input  logic [CW-1:0] dma_thresh,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          rdy_irq,
    output logic          dma_req
);

    logic rdy_pend;

    // Sticky flags: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            rdy_pend <= 1'b0;
        end else begin
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;

            if (unf_evt)      unf_flag <= 1'b1;
            else if (unf_clr) unf_flag <= 1'b0;

            if (wr_en)        rdy_pend <= 1'b1;
            else if (rdy_clr) rdy_pend <= 1'b0;
        end
    end

    always_comb begin
        rdy_irq = rdy_pend && !rdy_mask && nonempty;
        dma_req = dma_en && (count != '0) && (count >= dma_thresh);
    end

    // R6: flags hold until their own clear
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    a_r6_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (unf_flag && !unf_clr) |=> unf_flag);

    // R4: an overrun event is always recorded
    a_r4_ovf_set: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    // R8: an unmasked push always raises the ready interrupt next cycle
    a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdy_irq || rdy_mask));

    // R9: no request without enable
    a_r9_dma_gate: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> !dma_req);

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 26,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [WIDTH-1:0] conv_data,
    input  logic             rd_pop,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    fill_count,
    output logic             is_full,
    output logic             not_empty,
    output logic             data_ready,
    output logic             ovf_flag,
    input  logic             ovf_clr,
    output logic             unf_flag,
    input  logic             unf_clr,
    input  logic             rdy_mask,
    input  logic             rdy_clr,
    output logic             rdy_irq,
    input  logic             dma_en,
    input  logic [CW-1:0]    dma_thresh,
    output logic             dma_req
);

    logic          wr_en, rd_en, ovf_evt, unf_evt;
    logic [PW-1:0] wptr, rptr;
    logic          full_s, nonempty_s;

    adcf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (conv_done),
        .pop_req  (rd_pop),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .wptr     (wptr),
        .rptr     (rptr),
        .count    (fill_count),
        .full     (full_s),
        .nonempty (nonempty_s)
    );

    adcf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wptr    (wptr),
        .wr_word (conv_data),
        .rd_en   (rd_en),
        .rd_void (unf_evt),
        .rptr    (rptr),
        .rd_word (rd_data)
    );

    adcf_irq #(.DEPTH(DEPTH)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .ovf_evt    (ovf_evt),
        .unf_evt    (unf_evt),
        .nonempty   (nonempty_s),
        .count      (fill_count),
        .ovf_clr    (ovf_clr),
        .unf_clr    (unf_clr),
        .rdy_mask   (rdy_mask),
        .rdy_clr    (rdy_clr),
        .dma_en     (dma_en),
        .dma_thresh (dma_thresh),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag),
        .rdy_irq    (rdy_irq),
        .dma_req    (dma_req)
    );

    always_comb begin
        is_full    = full_s;
        not_empty  = nonempty_s;
        data_ready = nonempty_s;
    end

    // R10: a pop and a push on a full store end with one entry fewer
    a_r10_full_pair: assert property (@(posedge clk) disable iff (rst)
        (is_full && conv_done && rd_pop) |=> (fill_count == CW'(DEPTH - 1)));

    // R1: reset leaves no request behind
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (fill_count == '0 && !ovf_flag && !unf_flag && !rdy_irq));

endmodule

// File: tb/test_adc_result_fifo.sv
module test_adc_result_fifo;

    localparam int W  = 26;
    localparam int CW = 6;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_done = 1'b0;
    logic [W-1:0]  conv_data = '0;
    logic          rd_pop = 1'b0;
    logic [W-1:0]  rd_data;
    logic [CW-1:0] fill_count;
    logic          is_full, not_empty, data_ready;
    logic          ovf_flag, unf_flag, rdy_irq, dma_req;
    logic          ovf_clr = 1'b0, unf_clr = 1'b0;
    logic          rdy_mask = 1'b1, rdy_clr = 1'b0;
    logic          dma_en = 1'b0;
    logic [CW-1:0] dma_thresh = '0;

    int checks = 0;
    int errors = 0;

    adc_result_fifo i_adc_result_fifo (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .fill_count(fill_count),
        .is_full(is_full), .not_empty(not_empty), .data_ready(data_ready),
        .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .unf_flag(unf_flag),
        .unf_clr(unf_clr), .rdy_mask(rdy_mask), .rdy_clr(rdy_clr),
        .rdy_irq(rdy_irq), .dma_en(dma_en), .dma_thresh(dma_thresh),
        .dma_req(dma_req)
    );

    always #10 clk = ~clk;

    // Vector fields: push[60] pop[59] chk_rd[58] data[57:32] cnt[31:26] rd[25:0]
    localparam logic [60:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 26'h111, 6'd1, 26'h0},
        {1'b1, 1'b0, 1'b0, 26'h222, 6'd2, 26'h0},
        {1'b0, 1'b1, 1'b1, 26'h0,   6'd1, 26'h111},
        {1'b1, 1'b1, 1'b1, 26'h333, 6'd1, 26'h222},
        {1'b0, 1'b1, 1'b1, 26'h0,   6'd0, 26'h333},
        {1'b0, 1'b1, 1'b1, 26'h0,   6'd0, 26'h0},
        {1'b1, 1'b1, 1'b1, 26'h444, 6'd1, 26'h0},
        {1'b0, 1'b1, 1'b1, 26'h0,   6'd0, 26'h444}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Apply strobes for one clock, return at the following negative edge
    task automatic cyc(input logic p, input logic [W-1:0] d, input logic q,
                       input logic oc, input logic uc, input logic rc);
        conv_done = p; conv_data = d; rd_pop = q;
        ovf_clr = oc; unf_clr = uc; rdy_clr = rc;
        @(negedge clk);
        conv_done = 1'b0; rd_pop = 1'b0;
        ovf_clr = 1'b0; unf_clr = 1'b0; rdy_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", 32'(fill_count), 0);
        check("R1 flags", {26'd0, is_full, not_empty, data_ready, ovf_flag, unf_flag, rdy_irq}, 0);
        check("R1 rd_data", 32'(rd_data), 0);
        check("R1 dma_req", 32'(dma_req), 0);
        rst = 1'b0;
        @(negedge clk);

        // Vector table: R2, R5, R7, R10
        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k][60], VEC[k][57:32], VEC[k][59], 1'b0, 1'b0, 1'b0);
            check("R2 count vector", 32'(fill_count), 32'(VEC[k][31:26]));
            if (VEC[k][58]) check("R7/R5 rd_data vector", 32'(rd_data), 32'(VEC[k][25:0]));
        end

        // R5/R6 underrun flag behaviour
        check("R5 unf set", 32'(unf_flag), 1);
        cyc(0, 0, 0, 0, 0, 0);
        check("R6 unf sticky", 32'(unf_flag), 1);
        cyc(0, 0, 0, 0, 1, 0);
        check("R6 unf clear", 32'(unf_flag), 0);
        cyc(0, 0, 1, 0, 1, 0);
        check("R6 unf set wins", 32'(unf_flag), 1);
        cyc(0, 0, 0, 0, 1, 0);

        // Fill to the top: R2, R3
        for (int i = 0; i < 32; i++) cyc(1, W'(100 + i), 0, 0, 0, 0);
        check("R2 count full", 32'(fill_count), 32);
        check("R3 is_full", 32'(is_full), 1);
        check("R3 not_empty", 32'(not_empty), 1);
        check("R4 ovf before", 32'(ovf_flag), 0);

        // R4 overrun
        cyc(1, W'(999), 0, 0, 0, 0);
        check("R4 count kept", 32'(fill_count), 32);
        check("R4 ovf set", 32'(ovf_flag), 1);

        // R10 push and pop on full store, with a clear: R6 set wins
        cyc(1, W'(888), 1, 1, 0, 0);
        check("R10 count 31", 32'(fill_count), 31);
        check("R10 oldest out", 32'(rd_data), 100);
        check("R6 ovf set wins", 32'(ovf_flag), 1);
        check("R3 not full", 32'(is_full), 0);
        cyc(0, 0, 0, 1, 0, 0);
        check("R6 ovf clear", 32'(ovf_flag), 0);

        // Drain: R7 order, R4 dropped words absent
        for (int i = 0; i < 31; i++) begin
            cyc(0, 0, 1, 0, 0, 0);
            check("R7/R4 drain order", 32'(rd_data), 32'(101 + i));
        end
        check("R3 empty", 32'({not_empty, data_ready}), 0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R7 rd_data hold", 32'(rd_data), 131);

        // R8 ready interrupt
        cyc(1, W'(5), 0, 0, 0, 0);
        check("R8 masked", 32'(rdy_irq), 0);
        check("R3 data_ready", 32'(data_ready), 1);
        rdy_mask = 1'b0;
        #1;
        check("R8 unmasked", 32'(rdy_irq), 1);
        cyc(0, 0, 0, 0, 0, 1);
        check("R8 cleared", 32'(rdy_irq), 0);
        cyc(1, W'(6), 0, 0, 0, 0);
        check("R8 rearm", 32'(rdy_irq), 1);
        cyc(1, W'(7), 0, 0, 0, 1);
        check("R8 set wins", 32'(rdy_irq), 1);

        // R9 DMA threshold (count is 3)
        dma_thresh = 6'd5;
        dma_en = 1'b1;
        #1;
        check("R9 below", 32'(dma_req), 0);
        cyc(1, W'(8), 0, 0, 0, 0);
        check("R9 at 4", 32'(dma_req), 0);
        cyc(1, W'(9), 0, 0, 0, 0);
        check("R9 reached", 32'(dma_req), 1);
        dma_en = 1'b0;
        #1;
        check("R9 disabled", 32'(dma_req), 0);
        dma_en = 1'b1;
        dma_thresh = 6'd0;
        #1;
        check("R9 zero thresh", 32'(dma_req), 1);

        // R1 reset mid-run
        rst = 1'b1;
        cyc(0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        check("R1 count after", 32'(fill_count), 0);
        check("R1 irq/dma after", 32'({rdy_irq, dma_req, not_empty}), 0);
        check("R1 rd_data after", 32'(rd_data), 0);

        finish_run();
    end

endmodule